// File: doc/BRIEF.md
# Predicated Vector Address Sequencer

This block turns one vectorised load or store into a stream of per-element effective addresses. A start pulse latches the vector length, two predicate masks, the scalar/vector flags of the base, index, update and destination operands, and the addressing controls. After that the block emits one element per accepted handshake. Each element carries its effective address and the element indices of the source, destination and update operands. Memory access, data conversion and fault handling are left to downstream logic.

Base and index register values come from an external register-read port. The block drives an element number on `base_sel_o` and `idx_sel_o`, and the port returns the value combinationally in the same cycle. Each vector operand walks its own predicate mask and skips clear bits independently of the other operands. The sequence closes with a one-cycle `done_o` pulse. A start pulse that arrives while a sequence is running is ignored.

Top module: `vec_addr_seq`

## Requirements
- R1: After reset, and until a start pulse, `valid_o` and `done_o` are low.
- R2: Unit stride applies when the operands are not indexed, shift is off, the base is scalar and `stride_sel_i`=0. The address is base element 0 + sign-extended immediate + i·2^`op_width_i`, where `op_width_i` codes 0,1,2,3 mean 1, 2, 4 and 8 bytes and i is the source element index.
- R3: Element stride applies under the same conditions as R2 but with `stride_sel_i`=1 and a nonzero immediate. The address is base element 0 + i·immediate.
- R4: Splat applies under the same conditions as R2 but with `stride_sel_i`=1 and a zero immediate. Every element targets base element 0, and the source index stays 0.
- R5: A vector base with shift off selects vector-of-bases mode, whatever the value of `stride_sel_i`. The address is base element i + immediate.
- R6: Shift mode takes priority over every other immediate-form mode. The address is base + ((i·immediate) << `shift_amt_i`). The base is element i when the base is a vector and element 0 otherwise.
- R7: In indexed form the address is base element (i, or 0 if scalar) + index element (k, or 0 if scalar). When both base and index are scalar, exactly one element is issued.
- R8: In indexed form the index value is taken at the width given by `idx_ew_i` (codes 0..3 mean 8, 16, 32 and 64 bits). It is sign-extended when `sea_i`=1 and zero-extended otherwise.
- R9: Indexed form with `ffirst_i`=1 and a vector index becomes strided. The address is base element 0 + i·(index element 0), and i walks the source mask.
- R10: Each vector operand index moves to the next set bit of its mask: source mask for base, index and update, destination mask for destination. Scalar operands stay at index 0.
- R11: With a scalar destination, exactly one element is issued.
- R12: The sequence ends when any active index reaches the vector length, including during skipping, or when VL=0. `done_o` then pulses for one cycle and no further element is valid.
- R13: While `valid_o` is high and `ready_i` is low, the address and indices hold. They advance only on an accepted handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Latch the configuration and begin a sequence |
| vl_i | input | 7 | Vector length, 0..64 |
| src_mask_i | input | 64 | Source predicate mask |
| dst_mask_i | input | 64 | Destination predicate mask |
| base_vec_i | input | 1 | Base operand is a vector |
| idx_vec_i | input | 1 | Index operand is a vector |
| upd_vec_i | input | 1 | Update operand is a vector |
| dst_vec_i | input | 1 | Destination is a vector |
| indexed_i | input | 1 | Two-register indexed form |
| shift_mode_i | input | 1 | Shifted-stride mode (immediate form) |
| stride_sel_i | input | 1 | 0 unit stride, 1 element stride |
| ffirst_i | input | 1 | Fail-first requested |
| sea_i | input | 1 | Signed index extension |
| idx_ew_i | input | 2 | Index element width code |
| imm_i | input | 16 | Signed immediate |
| op_width_i | input | 2 | Access width code |
| shift_amt_i | input | 6 | Shift amount for shift mode |
| base_sel_o | output | 6 | Base element number requested |
| base_val_i | input | 64 | Base element value |
| idx_sel_o | output | 6 | Index element number requested |
| idx_val_i | input | 64 | Index element value |
| valid_o | output | 1 | Element output valid |
| ready_i | input | 1 | Consumer accepts the element |
| ea_o | output | 64 | Effective address |
| src_idx_o | output | 6 | Source element index |
| dst_idx_o | output | 6 | Destination element index |
| upd_idx_o | output | 6 | Update element index |
| done_o | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The hardest case to reach is an operand that runs out of predicate bits while the other operands still have elements left. The sequence must then end on that operand's skip and not on the vector length. The stimulus builds masks whose last set bit lies below VL on the source side in some cases and on the destination side in others, plus an all-clear source mask. In each case the element count and the exact cycle of `done_o` are compared. A separate case activates only the update and destination lanes, to show that the update index walks the source mask on its own.

// File: rtl/vas_pkg.sv
package vas_pkg;
  typedef enum logic [2:0] {
    M_SHIFT, M_VBASE, M_UNIT, M_ELEM, M_SPLAT, M_IDX, M_IDX_STR
  } mode_e;

  localparam int L_SRC = 0;
  localparam int L_IDX = 1;
  localparam int L_UPD = 2;
  localparam int L_DST = 3;
  localparam int LANES = 4;

  function automatic mode_e pick_mode(input logic indexed, input logic shf,
                                      input logic bv, input logic xv,
                                      input logic els, input logic ff,
                                      input logic imm_nz);
    mode_e m;
    if (indexed)     m = (ff && xv) ? M_IDX_STR : M_IDX;
    else if (shf)    m = M_SHIFT;
    else if (bv)     m = M_VBASE;
    else if (!els)   m = M_UNIT;
    else if (imm_nz) m = M_ELEM;
    else             m = M_SPLAT;
    return m;
  endfunction

  function automatic logic [LANES-1:0] lane_act(input mode_e m, input logic bv,
                                                input logic xv, input logic uv,
                                                input logic dv);
    logic [LANES-1:0] a;
    a[L_SRC] = bv || (m == M_SHIFT) || (m == M_UNIT) || (m == M_ELEM) || (m == M_IDX_STR);
    a[L_IDX] = (m == M_IDX) && xv;
    a[L_UPD] = uv;
    a[L_DST] = dv;
    return a;
  endfunction
endpackage

// File: rtl/vas_scan.sv
module vas_scan #(
  parameter int N  = 64,
  parameter int IW = 7
) (
  input  logic [N-1:0]  mask_i,
  input  logic [IW-1:0] from_i,
  output logic [IW-1:0] pos_o
);
  // lowest set bit at or above from_i, N if none
  always_comb begin
    pos_o = IW'(N);
    for (int b = N - 1; b >= 0; b--) begin
      if (mask_i[b] && (IW'(b) >= from_i)) pos_o = IW'(b);
    end
  end
endmodule

// File: rtl/vas_ea.sv
module vas_ea
  import vas_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IMM_W = 16,
  parameter int IW    = 7,
  parameter int SH_W  = 6
) (
  input  mode_e            mode_i,
  input  logic [IW-1:0]    step_i,
  input  logic [XLEN-1:0]  base_i,
  input  logic [XLEN-1:0]  index_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [1:0]       ow_i,
  input  logic [SH_W-1:0]  sh_i,
  input  logic             sea_i,
  input  logic [1:0]       ew_i,
  output logic [XLEN-1:0]  ea_o
);
  logic [XLEN-1:0] imm_x, step_x, prod, idx_x;

  assign imm_x  = {{(XLEN-IMM_W){imm_i[IMM_W-1]}}, imm_i};
  assign step_x = XLEN'(step_i);
  assign prod   = step_x * imm_x;

  always_comb begin
    case (ew_i)
      2'd0:    idx_x = {{(XLEN-8){sea_i & index_i[7]}}, index_i[7:0]};
      2'd1:    idx_x = {{(XLEN-16){sea_i & index_i[15]}}, index_i[15:0]};
      2'd2:    idx_x = {{(XLEN-32){sea_i & index_i[31]}}, index_i[31:0]};
      default: idx_x = index_i;
    endcase
  end

  always_comb begin
    case (mode_i)
      M_SHIFT:   ea_o = base_i + (prod << sh_i);
      M_VBASE:   ea_o = base_i + imm_x;
      M_UNIT:    ea_o = base_i + imm_x + (step_x << ow_i);
      M_ELEM:    ea_o = base_i + prod;
      M_IDX:     ea_o = base_i + idx_x;
      M_IDX_STR: ea_o = base_i + step_x * index_i;
      default:   ea_o = base_i + imm_x;
    endcase
  end
endmodule

// File: rtl/vec_addr_seq.sv
module vec_addr_seq
  import vas_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int MAX_VL = 64,
  parameter int IMM_W  = 16,
  localparam int EIW   = $clog2(MAX_VL),
  localparam int IW    = EIW + 1,
  localparam int SH_W  = $clog2(XLEN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [IW-1:0]     vl_i,
  input  logic [MAX_VL-1:0] src_mask_i,
  input  logic [MAX_VL-1:0] dst_mask_i,
  input  logic              base_vec_i,
  input  logic              idx_vec_i,
  input  logic              upd_vec_i,
  input  logic              dst_vec_i,
  input  logic              indexed_i,
  input  logic              shift_mode_i,
  input  logic              stride_sel_i,
  input  logic              ffirst_i,
  input  logic              sea_i,
  input  logic [1:0]        idx_ew_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [1:0]        op_width_i,
  input  logic [SH_W-1:0]   shift_amt_i,
  output logic [EIW-1:0]    base_sel_o,
  input  logic [XLEN-1:0]   base_val_i,
  output logic [EIW-1:0]    idx_sel_o,
  input  logic [XLEN-1:0]   idx_val_i,
  output logic              valid_o,
  input  logic              ready_i,
  output logic [XLEN-1:0]   ea_o,
  output logic [EIW-1:0]    src_idx_o,
  output logic [EIW-1:0]    dst_idx_o,
  output logic [EIW-1:0]    upd_idx_o,
  output logic              done_o
);
  typedef struct packed {
    logic [MAX_VL-1:0] sm;
    logic [MAX_VL-1:0] dm;
    logic [IW-1:0]     vl;
    mode_e             mode;
    logic              bv, xv, uv, dv, sea;
    logic [1:0]        ew, ow;
    logic [IMM_W-1:0]  imm;
    logic [SH_W-1:0]   sh;
  } cfg_t;

  cfg_t cfg_in, cfg_q, cfg_cur;
  logic busy_q, stop_q, start_fire, fire, in_range, end_one;
  logic [LANES-1:0] act_cur, act_q;
  logic [IW-1:0] lane_q [LANES];
  logic [IW-1:0] nxt [LANES];

  always_comb begin
    cfg_in.sm   = src_mask_i;
    cfg_in.dm   = dst_mask_i;
    cfg_in.vl   = vl_i;
    cfg_in.mode = pick_mode(indexed_i, shift_mode_i, base_vec_i, idx_vec_i,
                            stride_sel_i, ffirst_i, |imm_i);
    cfg_in.bv   = base_vec_i;
    cfg_in.xv   = idx_vec_i;
    cfg_in.uv   = upd_vec_i;
    cfg_in.dv   = dst_vec_i;
    cfg_in.sea  = sea_i;
    cfg_in.ew   = idx_ew_i;
    cfg_in.ow   = op_width_i;
    cfg_in.imm  = imm_i;
    cfg_in.sh   = shift_amt_i;
  end

  assign start_fire = start_i && !busy_q;
  assign cfg_cur    = start_fire ? cfg_in : cfg_q;
  assign act_cur    = lane_act(cfg_cur.mode, cfg_cur.bv, cfg_cur.xv, cfg_cur.uv, cfg_cur.dv);
  assign act_q      = lane_act(cfg_q.mode, cfg_q.bv, cfg_q.xv, cfg_q.uv, cfg_q.dv);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [MAX_VL-1:0] mask;
    logic [IW-1:0]     from;
    if (g == L_DST) begin : g_dm
      assign mask = cfg_cur.dm;
    end else begin : g_sm
      assign mask = cfg_cur.sm;
    end
    assign from = start_fire ? '0 : lane_q[g] + IW'(1);

    vas_scan #(.N(MAX_VL), .IW(IW)) u_scan (
      .mask_i(mask), .from_i(from), .pos_o(nxt[g])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   lane_q[g] <= '0;
      else if (start_fire)           lane_q[g] <= act_cur[g] ? nxt[g] : '0;
      else if (fire && act_q[g])     lane_q[g] <= nxt[g];
    end
  end

  always_comb begin
    in_range = busy_q && !stop_q && (cfg_q.vl != '0);
    for (int g = 0; g < LANES; g++) begin
      if (act_q[g] && (lane_q[g] >= cfg_q.vl)) in_range = 1'b0;
    end
  end

  assign valid_o = in_range;
  assign done_o  = busy_q && !in_range;
  assign fire    = valid_o && ready_i;
  assign end_one = !cfg_q.dv || ((cfg_q.mode == M_IDX) && !cfg_q.bv && !cfg_q.xv);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      stop_q <= 1'b0;
      cfg_q  <= '0;
    end else if (start_fire) begin
      busy_q <= 1'b1;
      stop_q <= 1'b0;
      cfg_q  <= cfg_in;
    end else if (done_o) begin
      busy_q <= 1'b0;
    end else if (fire && end_one) begin
      stop_q <= 1'b1;
    end
  end

  assign base_sel_o = (cfg_q.bv && (cfg_q.mode != M_IDX_STR)) ? lane_q[L_SRC][EIW-1:0] : '0;
  assign idx_sel_o  = lane_q[L_IDX][EIW-1:0];
  assign src_idx_o  = lane_q[L_SRC][EIW-1:0];
  assign upd_idx_o  = lane_q[L_UPD][EIW-1:0];
  assign dst_idx_o  = lane_q[L_DST][EIW-1:0];

  vas_ea #(.XLEN(XLEN), .IMM_W(IMM_W), .IW(IW), .SH_W(SH_W)) u_ea (
    .mode_i (cfg_q.mode),
    .step_i (lane_q[L_SRC]),
    .base_i (base_val_i),
    .index_i(idx_val_i),
    .imm_i  (cfg_q.imm),
    .ow_i   (cfg_q.ow),
    .sh_i   (cfg_q.sh),
    .sea_i  (cfg_q.sea),
    .ew_i   (cfg_q.ew),
    .ea_o   (ea_o)
  );

  assert_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(ea_o) && $stable(dst_idx_o) && $stable(src_idx_o));

  assert_done_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !valid_o);

  assert_dst_pred_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && cfg_q.dv |-> cfg_q.dm[dst_idx_o]);

  assert_src_pred_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && act_q[L_SRC] |-> cfg_q.sm[src_idx_o]);

  assert_scalar_dst_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && !cfg_q.dv |=> done_o);

  assert_idx_once_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && (cfg_q.mode == M_IDX) && !cfg_q.bv && !cfg_q.xv |=> done_o);
endmodule

// File: tb/sim_vec_addr_seq.sv
`timescale 1ns/1ps
module sim_vec_addr_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, ready = 1'b1;
  logic [6:0] vl = '0;
  logic [63:0] src_mask = '0, dst_mask = '0;
  logic bvec = 1'b0, xvec = 1'b0, uvec = 1'b0, dvec = 1'b0;
  logic indexed = 1'b0, shf = 1'b0, els = 1'b0, ff = 1'b0, sea = 1'b0;
  logic [1:0] ew = '0, ow = '0;
  logic [15:0] imm = '0;
  logic [5:0] sh = '0;
  logic [5:0] base_sel, idx_sel, src_idx, dst_idx, upd_idx;
  logic [63:0] base_val, idx_val, ea;
  logic valid, done;
  int n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  assign base_val = 64'h1000 + 64'(base_sel) * 64'h100;
  assign idx_val  = 64'h80 + 64'(idx_sel) * 64'h10;

  vec_addr_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .vl_i(vl),
    .src_mask_i(src_mask), .dst_mask_i(dst_mask),
    .base_vec_i(bvec), .idx_vec_i(xvec), .upd_vec_i(uvec), .dst_vec_i(dvec),
    .indexed_i(indexed), .shift_mode_i(shf), .stride_sel_i(els), .ffirst_i(ff),
    .sea_i(sea), .idx_ew_i(ew), .imm_i(imm), .op_width_i(ow), .shift_amt_i(sh),
    .base_sel_o(base_sel), .base_val_i(base_val), .idx_sel_o(idx_sel), .idx_val_i(idx_val),
    .valid_o(valid), .ready_i(ready), .ea_o(ea),
    .src_idx_o(src_idx), .dst_idx_o(dst_idx), .upd_idx_o(upd_idx), .done_o(done)
  );

  typedef struct packed {
    logic idx, bv, xv, dv, shf, els, ff, sea;
    logic [1:0] ew;
    logic [15:0] imm;
    logic [1:0] ow;
    logic [5:0] sh;
    logic [6:0] vl;
    logic [7:0] sm, dm;
    logic [2:0] n;
  } vec_t;

  localparam int NT = 15;
  localparam vec_t TBL [NT] = '{
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'd3,16'h0020,2'd2,6'd0,7'd4,8'hFF,8'hFF,3'd4},
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'd3,16'hFFF8,2'd3,6'd0,7'd3,8'h05,8'hFF,3'd2},
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,2'd3,16'h0040,2'd0,6'd0,7'd4,8'hFF,8'h0A,3'd2},
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,2'd3,16'h0000,2'd0,6'd0,7'd3,8'hFF,8'hFF,3'd3},
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'd3,16'h0008,2'd0,6'd0,7'd3,8'h06,8'hFF,3'd2},
    '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,2'd3,16'h0003,2'd0,6'd4,7'd3,8'hFF,8'hFF,3'd3},
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,2'd3,16'h0002,2'd0,6'd1,7'd3,8'hFF,8'hFF,3'd3},
    '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,2'd3,16'h0000,2'd0,6'd0,7'd3,8'h07,8'hFF,3'd3},
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'd3,16'h0000,2'd0,6'd0,7'd4,8'hFF,8'hFF,3'd1},
    '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,2'd0,16'h0000,2'd0,6'd0,7'd2,8'hFF,8'hFF,3'd2},
    '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,2'd0,16'h0000,2'd0,6'd0,7'd2,8'hFF,8'hFF,3'd2},
    '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,2'd3,16'h0000,2'd0,6'd0,7'd3,8'h0D,8'hFF,3'd2},
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd3,16'h0020,2'd2,6'd0,7'd4,8'hFF,8'hFF,3'd1},
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'd3,16'h0020,2'd2,6'd0,7'd0,8'hFF,8'hFF,3'd0},
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'd3,16'h0020,2'd2,6'd0,7'd4,8'h00,8'hFF,3'd0}
  };

  localparam logic [63:0] EXP_EA [NT][4] = '{
    '{64'h1020, 64'h1024, 64'h1028, 64'h102C},
    '{64'h0FF8, 64'h1008, 64'h0, 64'h0},
    '{64'h1000, 64'h1040, 64'h0, 64'h0},
    '{64'h1000, 64'h1000, 64'h1000, 64'h0},
    '{64'h1108, 64'h1208, 64'h0, 64'h0},
    '{64'h1000, 64'h1030, 64'h1060, 64'h0},
    '{64'h1000, 64'h1104, 64'h1208, 64'h0},
    '{64'h1080, 64'h1190, 64'h12A0, 64'h0},
    '{64'h1080, 64'h0, 64'h0, 64'h0},
    '{64'h0F80, 64'h0F90, 64'h0, 64'h0},
    '{64'h1080, 64'h1090, 64'h0, 64'h0},
    '{64'h1000, 64'h1100, 64'h0, 64'h0},
    '{64'h1020, 64'h0, 64'h0, 64'h0},
    '{64'h0, 64'h0, 64'h0, 64'h0},
    '{64'h0, 64'h0, 64'h0, 64'h0}
  };

  localparam logic [5:0] EXP_SI [NT][4] = '{
    '{6'd0,6'd1,6'd2,6'd3}, '{6'd0,6'd2,6'd0,6'd0}, '{6'd0,6'd1,6'd0,6'd0},
    '{6'd0,6'd0,6'd0,6'd0}, '{6'd1,6'd2,6'd0,6'd0}, '{6'd0,6'd1,6'd2,6'd0},
    '{6'd0,6'd1,6'd2,6'd0}, '{6'd0,6'd1,6'd2,6'd0}, '{6'd0,6'd0,6'd0,6'd0},
    '{6'd0,6'd0,6'd0,6'd0}, '{6'd0,6'd0,6'd0,6'd0}, '{6'd0,6'd2,6'd0,6'd0},
    '{6'd0,6'd0,6'd0,6'd0}, '{6'd0,6'd0,6'd0,6'd0}, '{6'd0,6'd0,6'd0,6'd0}
  };

  localparam logic [5:0] EXP_DI [NT][4] = '{
    '{6'd0,6'd1,6'd2,6'd3}, '{6'd0,6'd1,6'd0,6'd0}, '{6'd1,6'd3,6'd0,6'd0},
    '{6'd0,6'd1,6'd2,6'd0}, '{6'd0,6'd1,6'd0,6'd0}, '{6'd0,6'd1,6'd2,6'd0},
    '{6'd0,6'd1,6'd2,6'd0}, '{6'd0,6'd1,6'd2,6'd0}, '{6'd0,6'd0,6'd0,6'd0},
    '{6'd0,6'd1,6'd0,6'd0}, '{6'd0,6'd1,6'd0,6'd0}, '{6'd0,6'd1,6'd0,6'd0},
    '{6'd0,6'd0,6'd0,6'd0}, '{6'd0,6'd0,6'd0,6'd0}, '{6'd0,6'd0,6'd0,6'd0}
  };

  function automatic string tag(input int t);
    case (t)
      0:       return "R2";
      1:       return "R2/R10";
      2:       return "R3/R10";
      3:       return "R4";
      4:       return "R5/R10";
      5, 6:    return "R6";
      7, 8:    return "R7";
      9, 10:   return "R8";
      11:      return "R9";
      12:      return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic load_cfg(input vec_t v, input logic uv);
    indexed = v.idx; bvec = v.bv; xvec = v.xv; dvec = v.dv; uvec = uv;
    shf = v.shf; els = v.els; ff = v.ff; sea = v.sea; ew = v.ew;
    imm = v.imm; ow = v.ow; sh = v.sh; vl = v.vl;
    src_mask = {56'h0, v.sm}; dst_mask = {56'h0, v.dm};
  endtask

  task automatic kick();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic run_case(input int t);
    int cnt = 0;
    string req = tag(t);
    @(negedge clk);
    load_cfg(TBL[t], 1'b0);
    kick();
    for (int c = 0; c < 100; c++) begin
      if (done) break;
      if (valid) begin
        if (cnt < 4) begin
          chk(req, "ea", ea, EXP_EA[t][cnt]);
          chk(req, "src_idx", 64'(src_idx), 64'(EXP_SI[t][cnt]));
          chk(req, "dst_idx", 64'(dst_idx), 64'(EXP_DI[t][cnt]));
        end else chk(req, "extra element", 64'(cnt), 64'(TBL[t].n));
        cnt++;
      end
      @(negedge clk);
    end
    chk(req, "element count", 64'(cnt), 64'(TBL[t].n));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    // R1: reset and idle
    repeat (3) @(negedge clk);
    chk("R1", "valid in reset", 64'(valid), 64'd0);
    chk("R1", "done in reset", 64'(done), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "valid idle", 64'(valid), 64'd0);
    chk("R1", "done idle", 64'(done), 64'd0);

    for (int t = 0; t < NT; t++) run_case(t);

    // R13: stall holds outputs
    @(negedge clk);
    load_cfg(TBL[0], 1'b0);
    ready = 1'b0;
    kick();
    for (int c = 0; c < 3; c++) begin
      chk("R13", "valid stalled", 64'(valid), 64'd1);
      chk("R13", "ea stalled", ea, 64'h1020);
      chk("R13", "dst stalled", 64'(dst_idx), 64'd0);
      @(negedge clk);
    end
    ready = 1'b1;
    @(negedge clk);
    chk("R13", "ea after accept", ea, 64'h1024);
    for (int c = 0; c < 20 && !done; c++) @(negedge clk);
    chk("R12", "done after stall case", 64'(done), 64'd1);

    // R10: update lane walks source mask on its own, splat base
    @(negedge clk);
    load_cfg(TBL[3], 1'b1);
    vl = 7'd4; src_mask = 64'h6;
    kick();
    chk("R10", "upd first", 64'(upd_idx), 64'd1);
    chk("R10", "dst first", 64'(dst_idx), 64'd0);
    chk("R10", "ea first", ea, 64'h1000);
    @(negedge clk);
    chk("R10", "upd second", 64'(upd_idx), 64'd2);
    chk("R10", "dst second", 64'(dst_idx), 64'd1);
    @(negedge clk);
    chk("R12", "done when update mask runs out", 64'(done), 64'd1);
    chk("R12", "no valid at done", 64'(valid), 64'd0);
    @(negedge clk);
    chk("R12", "done single pulse", 64'(done), 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule